// File: doc/BRIEF.md
# Program Flow Trace Capture Buffer

This block records the debug status that a processor drives on its trace pins, one sample per clock, into a circular on-chip store. Each record holds a 3-bit instruction-queue status code, a 2-bit flush status code, a per-cycle program-trace attribute, and the bus address. The address is kept only on cycles that carry the attribute. A status code of 3'b101 marks an indirect-branch-type event, and the next attributed address in the stream is that event's target. Records are kept unchanged so that later software can rebuild the flow.

A level-sensitive synchronization input, asynchronous to the clock, decides when capture ends. In back-trace mode, recording starts as soon as reset or clear is released. The buffer overwrites its oldest records, and capture freezes on the first negation after an assertion, which leaves the history just before that event. In window mode, only cycles during which the synchronized input is high are recorded, and capture freezes on its negation. Once frozen, the block raises `done_o`, and host logic drains the records oldest first through a simple read port. `wrapped_o` reports whether the history was truncated. A clear pulse re-arms the block.

Top module: `trace_capture_buf`

## Requirements
- R1: While capture is active, every clock cycle writes exactly one record laid out as {attr[37], vf[36:34], vfls[33:32], addr[31:0]}. The status codes, including the indirect-branch code 3'b101, are stored unmodified.
- R2: The addr field of a record equals addr_i when trace_attr_i was 1 in that cycle, and is all zeros otherwise.
- R3: sync_i passes through two flip-flops before use. A level change on sync_i affects capture decisions from the third rising edge after it.
- R4: In back-trace mode (mode 0), capture runs from the first cycle after reset or clear. It does not stop until the synchronized sync has been seen high and then goes low.
- R5: In back-trace mode, when more records arrive than DEPTH (a power of two, default 16), the oldest are overwritten and only the last DEPTH remain. wrapped_o is 1 exactly when DEPTH or more records were written since re-arming.
- R6: In window mode (mode 1), only cycles in which the synchronized sync is high are recorded, and capture freezes on its negation.
- R7: The mode is taken from mode_i on every cycle in which rst_n is low or clear_i is high, and is held otherwise.
- R8: done_o rises when capture freezes and stays high until clear. While it is high, the status, address and sync inputs change neither the stored records nor wrapped_o.
- R9: After done_o, each accepted rd_en_i pulse yields rd_valid_o one cycle later with the next record, oldest first. The oldest record is slot 0 if the buffer has not wrapped, and the write slot otherwise.
- R10: rd_en_i before done_o, or after all stored records have been read, produces no rd_valid_o.
- R11: clear_i empties the buffer and drops done_o, wrapped_o and rd_valid_o on the next cycle. After reset the same three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Capture mode: 0 back trace, 1 window |
| clear_i | input | 1 | Re-arm capture and empty the buffer |
| sync_i | input | 1 | Asynchronous synchronization level |
| vf_i | input | 3 | Instruction-queue status code |
| vfls_i | input | 2 | Flush status code |
| addr_i | input | 32 | Bus address |
| trace_attr_i | input | 1 | Program-trace cycle attribute |
| rd_en_i | input | 1 | Read request for the next record |
| rd_data_o | output | 38 | Record returned by a read |
| rd_valid_o | output | 1 | rd_data_o holds a record this cycle |
| done_o | output | 1 | Capture has frozen |
| wrapped_o | output | 1 | Older records were overwritten |

## Verification
Back trace is run twice. A short run shows that records start at reset and that an idle low sync does not stop capture. A long run forces overwriting, which separates a correct oldest-first start from a naive start at slot zero. Window mode is run with a long low idle before the pulse, so that any record taken outside the pulse shows up. A second window run has a pulse longer than the store, which exercises wrapping in that mode. Mixed attributed and non-attributed cycles, including a 3'b101 code followed by its target, test address blanking. Activity after freezing, and reads beyond the stored count, show that the frozen state does not change.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

  localparam int ADDR_W = 32;
  localparam int VF_W   = 3;
  localparam int VFLS_W = 2;
  localparam int REC_W  = 1 + VF_W + VFLS_W + ADDR_W;

  typedef struct packed {
    logic              attr;
    logic [VF_W-1:0]   vf;
    logic [VFLS_W-1:0] vfls;
    logic [ADDR_W-1:0] addr;
  } trace_rec_t;

  typedef enum logic {
    MODE_BACK   = 1'b0,
    MODE_WINDOW = 1'b1
  } cap_mode_e;

  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_FROZEN = 1'b1
  } cap_state_e;

  // First slot to read: slot 0 until the store has wrapped, then the write slot.
  function automatic int unsigned oldest_slot(int unsigned wslot, logic wrapped);
    return wrapped ? wslot : 0;
  endfunction

  // Number of valid records held in the store.
  function automatic int unsigned held_count(int unsigned wslot, logic wrapped,
                                             int unsigned depth);
    return wrapped ? depth : wslot;
  endfunction

  // Slot reached by stepping forward from base, modulo depth.
  function automatic int unsigned slot_after(int unsigned base, int unsigned step,
                                             int unsigned depth);
    return (base + step) % depth;
  endfunction

endpackage

// File: rtl/trace_sync.sv
module trace_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              level_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain      <= '0;
      level_prev <= 1'b0;
    end else begin
      chain      <= {chain[STAGES-2:0], async_i};
      level_prev <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign fall_o  = level_prev & ~chain[STAGES-1];

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          mode_i,
  input  logic          sync_lvl_i,
  input  logic          sync_fall_i,
  input  logic          rd_en_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_slot_o,
  output logic          rd_fire_o,
  output logic [AW-1:0] rd_slot_o,
  output logic          done_o,
  output logic          wrapped_o
);

  cap_state_e    state;
  cap_mode_e     mode_q;
  logic          seen_high;
  logic [AW-1:0] wslot;
  logic          wrapped;
  logic [CW-1:0] rd_idx;

  logic          freeze_evt;
  logic [CW-1:0] stored;
  logic [AW-1:0] first_slot;

  assign stored     = CW'(held_count(int'(wslot), wrapped, DEPTH));
  assign first_slot = AW'(oldest_slot(int'(wslot), wrapped));

  assign freeze_evt = (state == ST_RUN) && seen_high && sync_fall_i;
  assign wr_en_o    = (state == ST_RUN) && !clear_i &&
                      ((mode_q == MODE_BACK) || sync_lvl_i);
  assign rd_fire_o  = (state == ST_FROZEN) && !clear_i && rd_en_i && (rd_idx < stored);
  assign rd_slot_o  = AW'(slot_after(int'(first_slot), int'(rd_idx), DEPTH));
  assign wr_slot_o  = wslot;
  assign done_o     = (state == ST_FROZEN);
  assign wrapped_o  = wrapped;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      state     <= ST_RUN;
      mode_q    <= cap_mode_e'(mode_i);
      seen_high <= 1'b0;
      wslot     <= '0;
      wrapped   <= 1'b0;
      rd_idx    <= '0;
    end else begin
      if (wr_en_o) begin
        wslot <= wslot + AW'(1);
        if (wslot == AW'(DEPTH - 1)) wrapped <= 1'b1;
      end
      if ((state == ST_RUN) && sync_lvl_i) seen_high <= 1'b1;
      if (freeze_evt) state <= ST_FROZEN;
      if (rd_fire_o) rd_idx <= rd_idx + CW'(1);
    end
  end

  a_r10_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx <= stored);

  a_r5_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped && !clear_i |=> wrapped);

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !clear_i |=> done_o);

  a_r8_slot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !clear_i |=> $stable(wslot));

  a_r4_freeze_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |-> seen_high && !sync_lvl_i);

endmodule

// File: rtl/trace_store.sv
module trace_store
  import trace_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_slot_i,
  input  trace_rec_t    wr_rec_i,
  input  logic          rd_fire_i,
  input  logic [AW-1:0] rd_slot_i,
  output trace_rec_t    rd_rec_o,
  output logic          rd_valid_o
);

  trace_rec_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_slot_i] <= wr_rec_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      rd_valid_o <= 1'b0;
      rd_rec_o   <= '0;
    end else begin
      rd_valid_o <= rd_fire_i;
      if (rd_fire_i) rd_rec_o <= mem[rd_slot_i];
    end
  end

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import trace_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              clear_i,
  input  logic              sync_i,
  input  logic [VF_W-1:0]   vf_i,
  input  logic [VFLS_W-1:0] vfls_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              trace_attr_i,
  input  logic              rd_en_i,
  output logic [REC_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o,
  output logic              wrapped_o
);

  if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_depth_check
    $error("trace_capture_buf: DEPTH must be a power of two");
  end

  logic          sync_lvl;
  logic          sync_fall;
  logic          wr_en;
  logic [AW-1:0] wr_slot;
  logic          rd_fire;
  logic [AW-1:0] rd_slot;
  trace_rec_t    wr_rec;
  trace_rec_t    rd_rec;

  always_comb begin
    wr_rec.attr = trace_attr_i;
    wr_rec.vf   = vf_i;
    wr_rec.vfls = vfls_i;
    wr_rec.addr = trace_attr_i ? addr_i : '0;
  end

  trace_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sync_i),
    .level_o (sync_lvl),
    .fall_o  (sync_fall)
  );

  trace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .mode_i      (mode_i),
    .sync_lvl_i  (sync_lvl),
    .sync_fall_i (sync_fall),
    .rd_en_i     (rd_en_i),
    .wr_en_o     (wr_en),
    .wr_slot_o   (wr_slot),
    .rd_fire_o   (rd_fire),
    .rd_slot_o   (rd_slot),
    .done_o      (done_o),
    .wrapped_o   (wrapped_o)
  );

  trace_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .wr_en_i    (wr_en),
    .wr_slot_i  (wr_slot),
    .wr_rec_i   (wr_rec),
    .rd_fire_i  (rd_fire),
    .rd_slot_i  (rd_slot),
    .rd_rec_o   (rd_rec),
    .rd_valid_o (rd_valid_o)
  );

  assign rd_data_o = rd_rec;

  a_r2_blank_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_data_o[REC_W-1] |-> rd_data_o[ADDR_W-1:0] == '0);

  a_r10_valid_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_en_i) && $past(done_o));

  a_r11_clear_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !done_o && !wrapped_o && !rd_valid_o);

  a_r8_wrap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !clear_i |=> $stable(wrapped_o));

endmodule

// File: tb/tb_trace_capture_buf.sv
module tb_trace_capture_buf;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_i = 1'b0;
  logic        clear_i = 1'b0;
  logic        sync_i = 1'b0;
  logic [2:0]  vf_i = '0;
  logic [1:0]  vfls_i = '0;
  logic [31:0] addr_i = '0;
  logic        trace_attr_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [37:0] rd_data_o;
  logic        rd_valid_o;
  logic        done_o;
  logic        wrapped_o;

  always #5 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clear_i(clear_i), .sync_i(sync_i),
    .vf_i(vf_i), .vfls_i(vfls_i), .addr_i(addr_i), .trace_attr_i(trace_attr_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .done_o(done_o), .wrapped_o(wrapped_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int popped = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  bit m_s1, m_s2, m_sd, m_run, m_seen, m_mode;
  logic [37:0] hist[$];
  logic [37:0] exp_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_sd = 0;
      m_run = 1; m_seen = 0; m_mode = mode_i;
      hist.delete();
    end else begin
      if (clear_i) begin
        m_run = 1; m_seen = 0; m_mode = mode_i;
        hist.delete();
      end else if (m_run) begin
        if (!m_mode || m_s2)
          hist.push_back({trace_attr_i, vf_i, vfls_i, trace_attr_i ? addr_i : 32'h0});
        if (!m_s2 && m_sd && m_seen) m_run = 0;
        if (m_s2) m_seen = 1;
      end
      m_sd = m_s2; m_s2 = m_s1; m_s1 = sync_i;
    end
  end

  // Monitor: compares each returned record with the scoreboard queue (R9).
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected rd_valid", 64'(rd_data_o), 64'h0);
      end else begin
        logic [37:0] e;
        e = exp_q.pop_front();
        popped++;
        check(rd_data_o === e, "R9/R1/R2 record order and content", 64'(rd_data_o), 64'(e));
      end
    end
  end

  task automatic cycles(input int n, input bit s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync_i = s;
      vf_i = 3'($urandom);
      vfls_i = 2'($urandom);
      addr_i = $urandom;
      trace_attr_i = 1'($urandom);
    end
  endtask

  task automatic branch_pair(input logic [31:0] target);
    @(negedge clk);
    vf_i = 3'b101; vfls_i = 2'b00; addr_i = 32'hdead_0000; trace_attr_i = 1'b0;
    @(negedge clk);
    vf_i = 3'b000; vfls_i = 2'b01; addr_i = target; trace_attr_i = 1'b1;
  endtask

  task automatic do_clear(input bit md);
    @(negedge clk);
    clear_i = 1'b1; mode_i = md; sync_i = 1'b0;
    @(negedge clk);
    clear_i = 1'b0;
    check(!done_o && !wrapped_o && !rd_valid_o, "R11 clear rearms",
          64'({done_o, wrapped_o, rd_valid_o}), 64'h0);
  endtask

  // Driver: pushes expected records, then requests them plus three extra reads.
  task automatic drain(input string tag);
    int want;
    int start;
    @(negedge clk);
    check(done_o === 1'b1 && !m_run, {tag, " done after negation"}, 64'(done_o), 64'h1);
    check(wrapped_o === (hist.size() >= DEPTH), "R5 wrapped flag",
          64'(wrapped_o), 64'(hist.size() >= DEPTH));
    want = (hist.size() > DEPTH) ? DEPTH : hist.size();
    start = hist.size() - want;
    for (int i = 0; i < want; i++) exp_q.push_back(hist[start + i]);
    popped = 0;
    for (int i = 0; i < want + 3; i++) begin
      @(negedge clk);
      rd_en_i = 1'b1;
    end
    @(negedge clk);
    rd_en_i = 1'b0;
    repeat (2) @(negedge clk);
    check(popped == want, "R3/R5/R6 record count", 64'(popped), 64'(want));
    check(exp_q.size() == 0, "R10 all records returned", 64'(exp_q.size()), 64'h0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mode_i = 1'b0;
    repeat (4) @(negedge clk);
    check(!done_o && !wrapped_o && !rd_valid_o, "R11 reset state",
          64'({done_o, wrapped_o, rd_valid_o}), 64'h0);
    rst_n = 1'b1;

    // Back trace, short: capture from reset, low sync does not stop it.
    cycles(3, 1'b0);
    branch_pair(32'h0000_4a10);
    cycles(3, 1'b0);
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    @(negedge clk);
    check(!done_o, "R4 no stop without assertion", 64'(done_o), 64'h0);
    check(!rd_valid_o, "R10 read before done ignored", 64'(rd_valid_o), 64'h0);
    cycles(3, 1'b1);
    cycles(5, 1'b0);
    // Activity after freezing must not reach the store.
    cycles(4, 1'b1);
    cycles(4, 1'b0);
    check(done_o === 1'b1, "R8 done holds through later sync activity", 64'(done_o), 64'h1);
    drain("R4");

    // Back trace, long: overwriting keeps the last DEPTH records.
    do_clear(1'b0);
    cycles(40, 1'b0);
    branch_pair(32'h0000_8c04);
    cycles(2, 1'b1);
    cycles(5, 1'b0);
    drain("R5");

    // Window, short: long idle low, then a pulse (mode taken at clear, R7).
    do_clear(1'b1);
    cycles(12, 1'b0);
    check(!done_o, "R7/R6 window waits for assertion", 64'(done_o), 64'h0);
    cycles(5, 1'b1);
    cycles(5, 1'b0);
    drain("R6");

    // Window, long pulse: wraps inside the window.
    do_clear(1'b1);
    cycles(3, 1'b0);
    cycles(25, 1'b1);
    cycles(5, 1'b0);
    drain("R6");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule